// File: doc/BRIEF.md
# Modulating DDS Oscillator Core

This core is a numerically controlled oscillator with built-in modulation. A wide phase accumulator advances by one of two frequency words on every active clock edge. A pin picks which word is used, so frequency-shift keying is just a toggle of that pin. The most significant phase bits of the accumulator are summed with one of four phase-offset words, which a two-bit select picks, giving four-level phase-shift keying. The resulting phase indexes a sine table, and the table produces an unsigned amplitude code for an external DAC.

The frequency and phase words come in as plain input buses, driven by a separate register block. The output frequency is fclk × word / 2^ACC_W. A select change reaches the output after a fixed pipeline delay, so a modulator can schedule symbol edges exactly. An active-low reset clears only the oscillator's own state. An active-low sleep freezes the whole core in place.

Top module: `nco_mod_core`

## Requirements
- R1: On every rising clock edge with sleep_n high, the 32-bit phase accumulator adds the selected frequency word, modulo 2^32.
- R2: fsel = 0 selects freq0_word and fsel = 1 selects freq1_word. fsel is sampled on the rising clock edge.
- R3: psel (values 0..3) picks the offset word poff0..poff3. The offset is added to accumulator bits [31:20], and the sum wraps modulo 4096.
- R4: For a table phase p, let n = p[11] and m = p[10:0]. When m > 1024, m is replaced by 2048 − m. Then q = round(511·sin(π·m/2048)), and amp = 512 + q when n = 0, or 511 − q when n = 1. This gives 512 at p = 0, 1023 at 1024, 511 at 2048 and 0 at 3072.
- R5: Suppose fsel or psel changes before clock edge k. Then amp first reflects the change after edge k+5, which is six edges counting k, and it keeps the old value through edge k+4.
- R6: While rst_n is low, the accumulator and the pipeline are cleared asynchronously and amp reads 512. Let N be the number of edges after release, with freq0 selected. Then amp equals the R4 code of ((N−4)·freq0_word)[31:20] + poff0 for N ≥ 4. The frequency and phase words are unaffected, because they are inputs.
- R7: While sleep_n is low, all internal state holds and amp stays frozen. After sleep_n rises, the sequence continues as if the sleeping cycles had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low clear of accumulator and pipeline |
| sleep_n | input | 1 | Active-low freeze of all internal state |
| fsel | input | 1 | Frequency word select |
| psel | input | 2 | Phase offset select |
| freq0_word | input | 32 | Frequency word 0 |
| freq1_word | input | 32 | Frequency word 1 |
| poff0 | input | 12 | Phase offset word 0 |
| poff1 | input | 12 | Phase offset word 1 |
| poff2 | input | 12 | Phase offset word 2 |
| poff3 | input | 12 | Phase offset word 3 |
| amp | output | 10 | Offset-binary sine amplitude code |

## Verification
The frequency-word vectors each separate one aspect of the accumulator from the others:
- A zero step with various offsets reaches the table's cardinal points directly.
- A whole-step word and a half-step word show whether carries from the low fraction bits reach the top bits.
- A negative word shows wrap-around.
- A half-turn step with a three-quarter offset shows the modulo-4096 offset sum.

Idle registers are always loaded with distracting values, so a wrong select stands out. Separate select-edge walks count the edges before the output moves, which pins down the six-cycle latency. A sleep window confirms a held code and a resumed count, and a reset in mid-run shows the asynchronous return to midscale.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam real PI_C = 3.14159265358979323846;

  // Rounded quarter-wave magnitude for table slot k out of qn slots per quarter.
  function automatic int quarter_sine(input int k, input int qn, input int peak);
    real ang;
    ang = PI_C * real'(k) / (2.0 * real'(qn));
    return $rtoi(real'(peak) * $sin(ang) + 0.5);
  endfunction

  // Mirror an in-half phase onto the first quarter.
  function automatic int fold_quarter(input int low, input int qn);
    return (low > qn) ? (2 * qn - low) : low;
  endfunction

  // Offset-binary composition: upper half above mid, lower half below.
  function automatic int compose_amp(input bit neg, input int q, input int mid);
    return neg ? (mid - 1 - q) : (mid + q);
  endfunction

endpackage

// File: rtl/nco_sel_sync.sv
module nco_sel_sync #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fsel,
  input  logic [SEL_W-1:0] psel,
  output logic             fsel_q,
  output logic [SEL_W-1:0] psel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= 1'b0;
      psel_q <= '0;
    end else if (en) begin
      fsel_q <= fsel;
      psel_q <= psel;
    end
  end

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fsel_q) && $stable(psel_q));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int NPH   = 4,
  parameter int SEL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      fsel_q,
  input  logic [SEL_W-1:0]          psel_q,
  input  logic [1:0][ACC_W-1:0]     freq_w,
  input  logic [NPH-1:0][PH_W-1:0]  phase_w,
  output logic [PH_W-1:0]           ph
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step_w;
  logic [SEL_W-1:0] psel_d;
  logic [PH_W-1:0]  top_w;
  logic [PH_W-1:0]  off_w;
  logic [PH_W-1:0]  ph_q;

  assign step_w = freq_w[fsel_q];
  assign top_w  = acc_q[ACC_W-1 -: PH_W];
  assign off_w  = phase_w[psel_d];
  assign ph     = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      psel_d <= '0;
      ph_q   <= '0;
    end else if (en) begin
      acc_q  <= acc_q + step_w;
      psel_d <= psel_q;
      ph_q   <= top_w + off_w;
    end
  end

  p_acc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc_q == ACC_W'($past(acc_q) + $past(step_w)));

  p_off_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ph_q == PH_W'($past(top_w) + $past(off_w)));

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q) && $stable(ph_q) && $stable(psel_d));

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> acc_q == '0);

endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut #(
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PH_W-1:0]  ph,
  output logic [AMP_W-1:0] amp
);

  localparam int QN   = 2 ** (PH_W - 2);
  localparam int HALF = 2 ** (PH_W - 1);
  localparam int QW   = AMP_W - 1;
  localparam int MID  = 2 ** (AMP_W - 1);
  localparam int PEAK = MID - 1;

  logic [QW-1:0] rom [QN+1];

  for (genvar g = 0; g <= QN; g++) begin : g_rom
    localparam int QV = nco_pkg::quarter_sine(g, QN, PEAK);
    assign rom[g] = QW'(QV);
  end

  logic [PH_W-1:0]  low_w;
  logic [PH_W-1:0]  fold_w;
  logic             half4, half5;
  logic [PH_W-1:0]  idx4;
  logic [QW-1:0]    q5;
  logic [AMP_W-1:0] amp_d;
  logic [AMP_W-1:0] amp_q;

  assign low_w  = {1'b0, ph[PH_W-2:0]};
  assign fold_w = PH_W'(nco_pkg::fold_quarter(int'(low_w), QN));
  assign amp_d  = AMP_W'(nco_pkg::compose_amp(half5, int'(q5), MID));
  assign amp    = amp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half4 <= 1'b0;
      idx4  <= '0;
      half5 <= 1'b0;
      q5    <= '0;
      amp_q <= AMP_W'(MID);
    end else if (en) begin
      half4 <= ph[PH_W-1];
      idx4  <= fold_w;
      half5 <= half4;
      q5    <= rom[idx4];
      amp_q <= amp_d;
    end
  end

  p_fold_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx4 <= PH_W'(QN));

  p_peak_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && !half5 && (q5 == QW'(PEAK)) |=> amp_q == {AMP_W{1'b1}});

  p_trough_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && half5 && (q5 == QW'(PEAK)) |=> amp_q == '0);

  p_amp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(amp_q) && $stable(q5) && $stable(idx4));

  p_reset_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> amp_q == AMP_W'(MID));

endmodule

// File: rtl/nco_mod_core.sv
module nco_mod_core #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int AMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_n,
  input  logic             fsel,
  input  logic [1:0]       psel,
  input  logic [ACC_W-1:0] freq0_word,
  input  logic [ACC_W-1:0] freq1_word,
  input  logic [PH_W-1:0]  poff0,
  input  logic [PH_W-1:0]  poff1,
  input  logic [PH_W-1:0]  poff2,
  input  logic [PH_W-1:0]  poff3,
  output logic [AMP_W-1:0] amp
);

  localparam int NPH   = 4;
  localparam int SEL_W = $clog2(NPH);

  logic                     en_w;
  logic                     fsel_q;
  logic [SEL_W-1:0]         psel_q;
  logic [1:0][ACC_W-1:0]    freq_pack;
  logic [NPH-1:0][PH_W-1:0] phase_pack;
  logic [PH_W-1:0]          ph_w;

  assign en_w       = sleep_n;
  assign freq_pack  = {freq1_word, freq0_word};
  assign phase_pack = {poff3, poff2, poff1, poff0};

  nco_sel_sync #(.SEL_W(SEL_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_w),
    .fsel   (fsel),
    .psel   (psel),
    .fsel_q (fsel_q),
    .psel_q (psel_q)
  );

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W), .NPH(NPH), .SEL_W(SEL_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_w),
    .fsel_q  (fsel_q),
    .psel_q  (psel_q),
    .freq_w  (freq_pack),
    .phase_w (phase_pack),
    .ph      (ph_w)
  );

  nco_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_w),
    .ph    (ph_w),
    .amp   (amp)
  );

  p_out_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> $stable(amp));

endmodule

// File: tb/tb_nco_mod_core.sv
module tb_nco_mod_core;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // {frequency word, phase offset (16b), edge count after reset release (16b)}
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h0000_0000, 16'h0000, 16'd10},
    {32'h0000_0000, 16'h0400, 16'd8},
    {32'h0000_0000, 16'h0C00, 16'd8},
    {32'h0010_0000, 16'h0000, 16'd20},
    {32'h0008_0000, 16'h0005, 16'd37},
    {32'hFFF0_0000, 16'h0000, 16'd9},
    {32'h4000_0000, 16'h0000, 16'd7},
    {32'h8000_0000, 16'h0C00, 16'd5},
    {32'h1234_5678, 16'h07FF, 16'd50}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_n = 1'b1;
  logic        fsel = 1'b0;
  logic [1:0]  psel = 2'd0;
  logic [31:0] freq0_word = '0;
  logic [31:0] freq1_word = '0;
  logic [11:0] poff0 = '0, poff1 = '0, poff2 = '0, poff3 = '0;
  logic [9:0]  amp;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_mod_core dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fsel(fsel), .psel(psel),
    .freq0_word(freq0_word), .freq1_word(freq1_word),
    .poff0(poff0), .poff1(poff1), .poff2(poff2), .poff3(poff3), .amp(amp)
  );

  function automatic int ref_amp(input int p);
    int pm;
    real s;
    int q;
    pm = p & 4095;
    s = $sin(2.0 * 3.14159265358979323846 * real'(pm) / 4096.0);
    if (s < 0.0) s = -s;
    q = $rtoi(511.0 * s + 0.5);
    return (pm < 2048) ? (512 + q) : (511 - q);
  endfunction

  function automatic int top_after(input int steps, input logic [31:0] f);
    longint prod;
    logic [31:0] a;
    prod = longint'(steps) * longint'({32'd0, f});
    a = prod[31:0];
    return int'(a[31:20]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: amp=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R6 async clear", int'(amp), 512);
    @(negedge clk);
    @(negedge clk);
    check("R6 held in reset", int'(amp), 512);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 R3 R4: vector walk; idle words hold distractors (R2 select)
    for (int i = 0; i < NVEC; i++) begin
      freq0_word = VEC[i][63:32];
      freq1_word = 32'hDEAD_BEEF;
      poff0 = VEC[i][27:16];
      poff1 = 12'h123; poff2 = 12'h456; poff3 = 12'h789;
      fsel = 1'b0; psel = 2'd0;
      do_reset();
      edges(int'(VEC[i][15:0]));
      check($sformatf("R1/R3/R4 vector %0d", i), int'(amp),
            ref_amp(top_after(int'(VEC[i][15:0]) - 4, VEC[i][63:32]) + int'(VEC[i][27:16])));
    end

    // R2 R5: frequency select latency, then a quarter-turn walk
    freq0_word = 32'h0; freq1_word = 32'h4000_0000;
    poff0 = 12'h0; fsel = 1'b0; psel = 2'd0;
    do_reset();
    edges(3);
    check("R2 freq0 idle", int'(amp), 512);
    fsel = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      edges(1);
      if (k <= 5) check("R5 fsel not yet", int'(amp), 512);
      else if (k == 6) check("R5 fsel at six", int'(amp), 1023);
      else if (k == 7) check("R2 freq1 half", int'(amp), 511);
      else if (k == 8) check("R2 freq1 three-quarter", int'(amp), 0);
      else check("R1 wrap to zero", int'(amp), 512);
    end
    fsel = 1'b0;

    // R3 R5: phase select latency over all four offsets
    freq0_word = 32'h0;
    poff0 = 12'd0; poff1 = 12'd1024; poff2 = 12'd3072; poff3 = 12'd2048;
    psel = 2'd0;
    do_reset();
    edges(3);
    psel = 2'd1;
    edges(5);
    check("R5 psel not yet", int'(amp), 512);
    edges(1);
    check("R5 psel at six", int'(amp), 1023);
    psel = 2'd2;
    edges(6);
    check("R3 offset two", int'(amp), 0);
    psel = 2'd3;
    edges(6);
    check("R3 offset three", int'(amp), 511);
    psel = 2'd0;

    // R7: sleep freezes output and resumes without lost cycles
    freq0_word = 32'h0010_0000; poff0 = 12'd0;
    do_reset();
    edges(20);
    check("R7 before sleep", int'(amp), ref_amp(16));
    sleep_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      edges(1);
      check("R7 frozen", int'(amp), ref_amp(16));
    end
    sleep_n = 1'b1;
    edges(5);
    check("R7 resumed", int'(amp), ref_amp(21));

    // R6: reset in mid-run, then restart from zero phase
    edges(7);
    do_reset();
    edges(12);
    check("R6 restart", int'(amp), ref_amp(8));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule